// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI and LO Result Registers

This unit sits beside the integer datapath of a 32-bit RISC core. It takes a 6-bit function code and two register operands. It can start a signed or unsigned multiply or divide, read the HI or LO result register, or load either of them from the first operand. Multiply uses a shift-add loop and divide uses a restoring loop. Each loop runs on operand magnitudes for one cycle per bit, and the signs are applied when the result is written back. The first operand is the multiplicand or dividend. The second operand is the multiplier or divisor.

While an operation is in flight, `busy` is high. A read that arrives during that time is not lost: the unit holds it and answers it with the new result in the cycle that `busy` falls. A load of HI or LO, or a new multiply or divide, that arrives while busy is dropped, and a sticky misuse flag is set. A divide by zero finishes in normal time, leaves a fixed result, and sets its own sticky flag.

Top module: `mdu_hilo`

## Requirements
- R1: Function code 011000 multiplies both operands as signed values. The 64-bit product goes upper half to HI and lower half to LO.
- R2: Function code 011001 multiplies both operands as unsigned values. The 64-bit product goes to HI and LO as in R1.
- R3: Function code 011010 divides as signed values. The quotient goes to LO, truncated toward zero. The remainder goes to HI and takes the sign of the dividend. 0x80000000 divided by 0xFFFFFFFF gives LO=0x80000000 and HI=0.
- R4: Function code 011011 divides as unsigned values, with the quotient in LO and the remainder in HI.
- R5: A divide, signed or unsigned, whose second operand is zero completes in normal time. It writes LO=0xFFFFFFFF and HI=the first operand, and sets `div0_flag`. That flag stays high until reset.
- R6: `busy` goes high on the edge that accepts a multiply or divide. It stays high for exactly 33 cycles (32 iteration cycles and one write-back cycle). HI and LO take the result on the edge where `busy` falls.
- R7: While idle, function code 010000 (read HI) or 010010 (read LO) drives `rd_valid` high for one cycle after the accepting edge, with the register value on `rd_data`.
- R8: The unit holds one read that arrives while busy. That read, or a read arriving in the write-back cycle, is answered on the edge `busy` falls, with the new result. A further read while one is held is dropped. `rd_valid` is never high together with `busy`.
- R9: While idle, function code 010001 loads HI from the first operand, and 010011 loads LO from the first operand.
- R10: A load of HI or LO, or a multiply or divide code, that arrives while busy leaves HI, LO and the operation in flight unchanged. It sets `misuse_err`, which stays high until reset.
- R11: A synchronous active-high reset clears HI, LO, `busy`, `rd_valid`, `rd_data`, `misuse_err` and `div0_flag`.
- R12: Any other function code has no effect on registers, flags or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Function code and operands are valid this cycle |
| op_func | input | 6 | Function code |
| op_src_a | input | 32 | First source operand |
| op_src_b | input | 32 | Second source operand |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Read result (HI or LO) |
| busy | output | 1 | Multiply or divide in flight |
| misuse_err | output | 1 | Sticky: register load or new operation issued while busy |
| div0_flag | output | 1 | Sticky: a divide by zero has completed |

## Verification
The write-back cycle is where two functions collide. The result write to HI and LO can coincide with an incoming load of HI or LO, or with an incoming read. The bench provokes this by driving the load or read exactly 33 cycles after the operation, when `busy` is still high on that edge. The load must be rejected with `misuse_err` raised and the result kept. The read must be answered on that same edge with the fresh result. A cycle-accurate behavioural model judges every cycle: it computes results with 64-bit integer arithmetic, and it also covers reads held from the middle of an operation.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  localparam int unsigned XLEN    = 32;
  localparam int unsigned FUNC_W  = 6;

  typedef enum logic [FUNC_W-1:0] {
    FN_RD_HI  = 6'b010000,
    FN_WR_HI  = 6'b010001,
    FN_RD_LO  = 6'b010010,
    FN_WR_LO  = 6'b010011,
    FN_MUL_S  = 6'b011000,
    FN_MUL_U  = 6'b011001,
    FN_DIV_S  = 6'b011010,
    FN_DIV_U  = 6'b011011
  } mdu_fn_e;

  // Multiply/divide codes share the upper four bits; bit 1 picks divide,
  // bit 0 picks unsigned.
  localparam logic [3:0] MD_GROUP = 4'b0110;

endpackage

// File: rtl/mdu_sign_prep.sv
module mdu_sign_prep #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         use_sign,
  output logic [W-1:0] a_mag,
  output logic [W-1:0] b_mag,
  output logic         neg_main,
  output logic         neg_rem
);
  logic a_neg, b_neg;

  always_comb begin
    a_neg    = use_sign & a[W-1];
    b_neg    = use_sign & b[W-1];
    a_mag    = a_neg ? -a : a;
    b_mag    = b_neg ? -b : b;
    neg_main = a_neg ^ b_neg;
    neg_rem  = a_neg;
  end
endmodule

// File: rtl/mdu_mul_iter.sv
module mdu_mul_iter #(
  parameter int unsigned W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] product
);
  logic [W-1:0] acc_hi, acc_lo, mc_q;
  logic [W:0]   partial;

  always_comb begin
    partial = {1'b0, acc_hi} + (acc_lo[0] ? {1'b0, mc_q} : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_hi <= '0;
      acc_lo <= '0;
      mc_q   <= '0;
    end else if (load) begin
      acc_hi <= '0;
      acc_lo <= mplier;
      mc_q   <= mcand;
    end else if (step) begin
      acc_hi <= partial[W:1];
      acc_lo <= {partial[0], acc_lo[W-1:1]};
    end
  end

  assign product = {acc_hi, acc_lo};
endmodule

// File: rtl/mdu_div_iter.sv
module mdu_div_iter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  logic [W-1:0] rem_q, quo_q, dvs_q;
  logic [W:0]   shifted;
  logic [W+1:0] trial;
  logic         fits;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    trial   = {1'b0, shifted} - {2'b00, dvs_q};
    fits    = ~trial[W+1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else if (load) begin
      rem_q <= '0;
      quo_q <= dividend;
      dvs_q <= divisor;
    end else if (step) begin
      rem_q <= fits ? trial[W-1:0] : shifted[W-1:0];
      quo_q <= {quo_q[W-2:0], fits};
    end
  end

  assign quotient  = quo_q;
  assign remainder = rem_q;
endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo #(
  parameter int unsigned W = mdu_pkg::XLEN
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic [5:0]   op_func,
  input  logic [W-1:0] op_src_a,
  input  logic [W-1:0] op_src_b,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  output logic         busy,
  output logic         misuse_err,
  output logic         div0_flag
);
  import mdu_pkg::*;

  localparam int unsigned CW = $clog2(W + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(W);

  logic [W-1:0]   hi_q, lo_q, a_raw_q;
  logic [CW-1:0]  cnt_q;
  logic           busy_q, kind_div_q, neg_main_q, neg_rem_q, dz_q;
  logic           rd_pend, pend_hi_q;
  logic           rdv_q, mis_q, dz_flag_q;
  logic [W-1:0]   rdd_q;

  logic           is_rd, is_wr, is_md, md_signed, md_div;
  logic           start, step, finish;
  logic [W-1:0]   a_mag, b_mag;
  logic           neg_main, neg_rem;
  logic [2*W-1:0] prod, prod_fix;
  logic [W-1:0]   quo, rem, quo_fix, rem_fix, res_hi, res_lo;

  always_comb begin
    is_rd     = (op_func == FN_RD_HI) || (op_func == FN_RD_LO);
    is_wr     = (op_func == FN_WR_HI) || (op_func == FN_WR_LO);
    is_md     = (op_func[5:2] == MD_GROUP);
    md_signed = ~op_func[0];
    md_div    = op_func[1];
    start     = op_valid & is_md & ~busy_q;
    step      = busy_q & (cnt_q != '0);
    finish    = busy_q & (cnt_q == '0);
  end

  mdu_sign_prep #(.W(W)) u_sign (
    .a        (op_src_a),
    .b        (op_src_b),
    .use_sign (md_signed),
    .a_mag    (a_mag),
    .b_mag    (b_mag),
    .neg_main (neg_main),
    .neg_rem  (neg_rem)
  );

  mdu_mul_iter #(.W(W)) u_mul (
    .clk     (clk),
    .rst     (rst),
    .load    (start & ~md_div),
    .step    (step & ~kind_div_q),
    .mcand   (a_mag),
    .mplier  (b_mag),
    .product (prod)
  );

  mdu_div_iter #(.W(W)) u_div (
    .clk       (clk),
    .rst       (rst),
    .load      (start & md_div),
    .step      (step & kind_div_q),
    .dividend  (a_mag),
    .divisor   (b_mag),
    .quotient  (quo),
    .remainder (rem)
  );

  // Sign restore and result selection for the write-back cycle
  always_comb begin
    prod_fix = neg_main_q ? -prod : prod;
    quo_fix  = neg_main_q ? -quo  : quo;
    rem_fix  = neg_rem_q  ? -rem  : rem;
    if (!kind_div_q) begin
      res_hi = prod_fix[2*W-1:W];
      res_lo = prod_fix[W-1:0];
    end else if (dz_q) begin
      res_hi = a_raw_q;
      res_lo = '1;
    end else begin
      res_hi = rem_fix;
      res_lo = quo_fix;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q       <= '0;
      lo_q       <= '0;
      a_raw_q    <= '0;
      cnt_q      <= '0;
      busy_q     <= 1'b0;
      kind_div_q <= 1'b0;
      neg_main_q <= 1'b0;
      neg_rem_q  <= 1'b0;
      dz_q       <= 1'b0;
      rd_pend    <= 1'b0;
      pend_hi_q  <= 1'b0;
      rdv_q      <= 1'b0;
      rdd_q      <= '0;
      mis_q      <= 1'b0;
      dz_flag_q  <= 1'b0;
    end else begin
      rdv_q <= 1'b0;
      if (busy_q) begin
        if (finish) begin
          busy_q  <= 1'b0;
          hi_q    <= res_hi;
          lo_q    <= res_lo;
          rd_pend <= 1'b0;
          if (kind_div_q && dz_q) dz_flag_q <= 1'b1;
          if (rd_pend) begin
            rdv_q <= 1'b1;
            rdd_q <= pend_hi_q ? res_hi : res_lo;
          end else if (op_valid && is_rd) begin
            rdv_q <= 1'b1;
            rdd_q <= (op_func == FN_RD_HI) ? res_hi : res_lo;
          end
        end else begin
          cnt_q <= cnt_q - CW'(1);
          if (op_valid && is_rd && !rd_pend) begin
            rd_pend   <= 1'b1;
            pend_hi_q <= (op_func == FN_RD_HI);
          end
        end
        if (op_valid && (is_wr || is_md)) mis_q <= 1'b1;
      end else if (op_valid) begin
        unique case (op_func)
          FN_RD_HI: begin rdv_q <= 1'b1; rdd_q <= hi_q; end
          FN_RD_LO: begin rdv_q <= 1'b1; rdd_q <= lo_q; end
          FN_WR_HI: hi_q <= op_src_a;
          FN_WR_LO: lo_q <= op_src_a;
          FN_MUL_S, FN_MUL_U, FN_DIV_S, FN_DIV_U: begin
            busy_q     <= 1'b1;
            cnt_q      <= CNT_LOAD;
            kind_div_q <= md_div;
            neg_main_q <= neg_main;
            neg_rem_q  <= neg_rem;
            dz_q       <= md_div && (op_src_b == '0);
            a_raw_q    <= op_src_a;
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_valid   = rdv_q;
  assign rd_data    = rdd_q;
  assign busy       = busy_q;
  assign misuse_err = mis_q;
  assign div0_flag  = dz_flag_q;
endmodule

// File: rtl/mdu_hilo_chk.sv
module mdu_hilo_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         op_valid,
  input logic [5:0]   op_func,
  input logic         busy,
  input logic         rd_valid,
  input logic         misuse_err,
  input logic         div0_flag,
  input logic         rd_pend,
  input logic [W-1:0] hi_q
);
  localparam int unsigned RW = $clog2(W + 2) + 1;
  localparam logic [RW-1:0] RUN_MAX = RW'(W + 1);

  logic [RW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)       run_len <= '0;
    else if (busy) run_len <= run_len + RW'(1);
    else           run_len <= '0;
  end

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_len < RUN_MAX)); // R6
  AST_BUSY_EXACT: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len == RUN_MAX)); // R6
  AST_IDLE_READ: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !busy && (op_func == 6'b010000 || op_func == 6'b010010)) |=> rd_valid); // R7
  AST_RDV_IDLE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !busy); // R8
  AST_PEND_SERVE: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && $past(rd_pend)) |-> rd_valid); // R8
  AST_HI_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && op_valid && op_func == 6'b010001) |=> ($stable(hi_q) || !busy)); // R10
  AST_MISUSE_STICKY: assert property (@(posedge clk) disable iff (rst)
    misuse_err |=> misuse_err); // R10
  AST_DIV0_STICKY: assert property (@(posedge clk) disable iff (rst)
    div0_flag |=> div0_flag); // R5
endmodule

bind mdu_hilo mdu_hilo_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .op_valid   (op_valid),
  .op_func    (op_func),
  .busy       (busy),
  .rd_valid   (rd_valid),
  .misuse_err (misuse_err),
  .div0_flag  (div0_flag),
  .rd_pend    (rd_pend),
  .hi_q       (hi_q)
);

// File: tb/mdu_hilo_tb_top.sv
`timescale 1ns/1ps
module mdu_hilo_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [5:0]  op_func = '0;
  logic [31:0] op_src_a = '0;
  logic [31:0] op_src_b = '0;
  logic        rd_valid, busy, misuse_err, div0_flag;
  logic [31:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mdu_hilo dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_func(op_func),
    .op_src_a(op_src_a), .op_src_b(op_src_b), .rd_valid(rd_valid),
    .rd_data(rd_data), .busy(busy), .misuse_err(misuse_err), .div0_flag(div0_flag)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  function automatic void ref_op(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b,
                                 output logic [31:0] h, output logic [31:0] l,
                                 output bit dz, output string tag);
    longint sa, sb, q, r;
    logic [63:0] p, ua, ub, uq, ur;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ua = {32'h0, a};
    ub = {32'h0, b};
    dz = 0;
    h = '0; l = '0; tag = "R1";
    case (fn)
      6'b011000: begin p = sa * sb; h = p[63:32]; l = p[31:0]; tag = "R1"; end
      6'b011001: begin p = ua * ub; h = p[63:32]; l = p[31:0]; tag = "R2"; end
      default: begin
        if (b == 32'h0) begin
          dz = 1; h = a; l = 32'hFFFF_FFFF; tag = "R5";
        end else if (fn == 6'b011010) begin
          q = sa / sb; r = sa % sb; l = q[31:0]; h = r[31:0]; tag = "R3";
        end else begin
          uq = ua / ub; ur = ua % ub; l = uq[31:0]; h = ur[31:0]; tag = "R4";
        end
      end
    endcase
  endfunction

  logic [31:0] m_hi, m_lo, m_nhi, m_nlo, m_rdd;
  bit m_busy, m_pend, m_psel_hi, m_err, m_dz, m_ndz, m_rdv;
  int m_left;
  string m_tag, m_ntag, m_rtag;

  always @(posedge clk) begin
    bit rd_in, wr_in, md_in;
    rd_in = op_valid && (op_func == 6'b010000 || op_func == 6'b010010);
    wr_in = op_valid && (op_func == 6'b010001 || op_func == 6'b010011);
    md_in = op_valid && (op_func[5:2] == 4'b0110);
    if (rst) begin
      m_hi = 0; m_lo = 0; m_busy = 0; m_pend = 0; m_err = 0; m_dz = 0;
      m_rdv = 0; m_rdd = 0; m_left = 0; m_tag = "R11"; m_rtag = "R11";
    end else begin
      m_rdv = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0; m_hi = m_nhi; m_lo = m_nlo; m_tag = m_ntag;
          if (m_ndz) m_dz = 1;
          if (m_pend) begin
            m_rdv = 1; m_rdd = m_psel_hi ? m_hi : m_lo; m_rtag = "R8"; m_pend = 0;
          end else if (rd_in) begin
            m_rdv = 1; m_rdd = (op_func == 6'b010000) ? m_hi : m_lo; m_rtag = "R8";
          end
        end else if (rd_in && !m_pend) begin
          m_pend = 1; m_psel_hi = (op_func == 6'b010000);
        end
        if (wr_in || md_in) m_err = 1;
      end else if (op_valid) begin
        if (rd_in) begin
          m_rdv = 1; m_rdd = (op_func == 6'b010000) ? m_hi : m_lo; m_rtag = m_tag;
        end else if (op_func == 6'b010001) begin
          m_hi = op_src_a; m_tag = "R9";
        end else if (op_func == 6'b010011) begin
          m_lo = op_src_a; m_tag = "R9";
        end else if (md_in) begin
          ref_op(op_func, op_src_a, op_src_b, m_nhi, m_nlo, m_ndz, m_ntag);
          m_busy = 1; m_left = 33;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(busy == m_busy, "R6 busy", 32'(busy), 32'(m_busy));
      check(rd_valid == m_rdv, "R7 rd_valid", 32'(rd_valid), 32'(m_rdv));
      if (m_rdv && rd_valid) check(rd_data == m_rdd, m_rtag, rd_data, m_rdd);
      check(misuse_err == m_err, "R10 misuse_err", 32'(misuse_err), 32'(m_err));
      check(div0_flag == m_dz, "R5 div0_flag", 32'(div0_flag), 32'(m_dz));
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_valid = 1'b1; op_func = fn; op_src_a = a; op_src_b = b;
  endtask

  task automatic idle();
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  // side: 0 none, else cycle index at which a side request is driven
  task automatic run_op(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b,
                        input int side_at, input logic [5:0] side_fn);
    drive(fn, a, b);
    for (int k = 1; k <= 34; k++) begin
      if (k == side_at) drive(side_fn, 32'hDEAD_BEEF, 32'h0);
      else idle();
    end
    drive(6'b010000, 0, 0);
    drive(6'b010010, 0, 0);
    idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #750000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] corner [5];
    logic [5:0]  ops [4];
    corner[0] = 32'h0; corner[1] = 32'h1; corner[2] = 32'hFFFF_FFFF;
    corner[3] = 32'h8000_0000; corner[4] = 32'h7FFF_FFFF;
    ops[0] = 6'b011000; ops[1] = 6'b011001; ops[2] = 6'b011010; ops[3] = 6'b011011;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    check(!busy && !rd_valid && !misuse_err && !div0_flag, "R11 flags", {busy, rd_valid, misuse_err, div0_flag}, 0);
    drive(6'b010000, 0, 0);
    drive(6'b010010, 0, 0);
    idle();

    // R9: register loads
    drive(6'b010001, 32'h1234_5678, 0);
    drive(6'b010011, 32'h9ABC_DEF0, 0);
    drive(6'b010000, 0, 0);
    drive(6'b010010, 0, 0);
    idle();

    // R12: unknown codes have no effect
    drive(6'b100000, 32'h5555_5555, 32'h1);
    @(negedge clk);
    check(!rd_valid && !busy, "R12", {rd_valid, busy}, 0);
    op_valid = 1'b0;
    drive(6'b011100, 32'h5555_5555, 32'h1);
    drive(6'b010000, 0, 0);
    drive(6'b010010, 0, 0);
    idle();

    // R1-R5 on corner operands, including 0x80000000 / -1 (R3) and zero divisor (R5)
    for (int f = 0; f < 4; f++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          run_op(ops[f], corner[i], corner[j], 0, 6'b0);

    // R8: read held while busy, at early, late and write-back cycles
    run_op(6'b011010, 32'hFFFF_FF85, 32'h0000_0007, 3, 6'b010010);
    run_op(6'b011000, 32'hFFFF_0003, 32'h0001_0005, 31, 6'b010000);
    run_op(6'b011011, 32'hF000_0001, 32'h0000_0013, 33, 6'b010000);

    // R10: load and new operation while busy are rejected, including at write-back
    run_op(6'b011001, 32'hABCD_0123, 32'h0F0F_F0F0, 5, 6'b010001);
    run_op(6'b011000, 32'h0000_1234, 32'hFFFF_FFFE, 10, 6'b011010);
    run_op(6'b011010, 32'h7000_0000, 32'hFFFF_FFFD, 33, 6'b010011);

    // Random operands and side requests
    for (int n = 0; n < 60; n++) begin
      logic [31:0] ra, rb;
      int sa;
      ra = $urandom();
      rb = (n % 7 == 0) ? ($urandom() & 32'hFF) : $urandom();
      sa = (n % 3 == 0) ? int'($urandom_range(1, 34)) : 0;
      run_op(ops[n % 4], ra, rb, sa, (n % 2 == 0) ? 6'b010010 : 6'b010001);
    end

    repeat (3) idle();
    finish_run();
  end
endmodule